// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Front End with Redirect Squash

This block is the front end of a two-stage processor pipeline. Stage one keeps the program counter and presents a word address to an instruction memory with a combinational read. Stage two decodes, executes, accesses data memory and writes back, all in one cycle. On each clock edge the front end captures the returned instruction word, together with the byte address it was fetched from, into the registers that feed stage two.

The execute stage evaluates branches and jumps and forms their targets. When it decides that control flow leaves the sequential path, it raises a redirect flag and supplies a byte target. The front end then loads that target into the program counter. It also replaces the instruction fetched in the same cycle with the no-operation word `0x00000013`, because that instruction lies on the wrong path. The front end does no target arithmetic. Reset places the no-operation word in the execute slot, so the pipeline starts with one empty cycle.

Top module: `fe_front_end`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, the fetch word address is RESET_PC/4 (0 by default), the execute instruction is `0x00000013` and the execute PC is RESET_PC.
- R2: When the redirect flag is low at a clock edge, the program counter advances by 4. The fetch word address always equals program counter bits 31 down to 2.
- R3: When the redirect flag is low at a clock edge, the execute instruction after that edge is the instruction word that was on the fetch input before the edge, unmodified.
- R4: After every clock edge outside reset, the execute PC equals the byte address that the program counter held before the edge.
- R5: When the redirect flag is high at a clock edge, the program counter after the edge equals the supplied 32-bit target, including its two low bits. The fetch word address becomes target bits 31 down to 2, and the following sequential step adds 4 to the full target.
- R6: When the redirect flag is high at a clock edge, the execute instruction after that edge is `0x00000013`, whatever word was on the fetch input.
- R7: Redirects on consecutive cycles each squash their own fetched word and each load their own target.
- R8: While the redirect flag is low, the value on the target input has no effect on the fetch address or on either execute output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_word_i | input | 32 | Instruction word returned for the current fetch address |
| redirect_i | input | 1 | Execute stage takes a jump or a taken branch this cycle |
| redirect_pc_i | input | 32 | Byte target for the redirect |
| fetch_waddr_o | output | 30 | Word address presented to instruction memory |
| ex_instr_o | output | 32 | Instruction held for the execute stage |
| ex_pc_o | output | 32 | Byte address of the instruction in the execute stage |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and a reset address of zero. With these values, the reset checks compare against a fetch address of 0, and the word address has 30 bits, so the unaligned target 0x203 checks that the two low bits are dropped from the fetch address but kept in the program counter. The stimulus contains long sequential runs, isolated and back-to-back redirects, a target input that changes while the flag is low, a reset in the middle of a run, and a long pseudo-random mix. Together these cover every ordering of redirect and sequential cycles.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam int XLEN    = 32;
    localparam int WADDR_W = XLEN - 2;
    localparam logic [XLEN-1:0] NOP_WORD = 32'h0000_0013;
    localparam logic [XLEN-1:0] PC_STEP  = 32'd4;

    typedef logic [XLEN-1:0]    word_t;
    typedef logic [WADDR_W-1:0] waddr_t;

    typedef struct packed {
        word_t instr;
        word_t pc;
    } ex_slot_t;

    function automatic waddr_t byte_to_word(input word_t a);
        return a[XLEN-1:2];
    endfunction
endpackage

// File: rtl/fe_pc_gen.sv
module fe_pc_gen
    import fe_pkg::*;
#(
    parameter word_t RESET_PC = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   redirect_i,
    input  word_t  target_i,
    output word_t  pc_o,
    output waddr_t waddr_o
);
    word_t pc_q;

    always_ff @(posedge clk) begin
        if (rst)             pc_q <= RESET_PC;
        else if (redirect_i) pc_q <= target_i;
        else                 pc_q <= pc_q + PC_STEP;
    end

    assign pc_o    = pc_q;
    assign waddr_o = byte_to_word(pc_q);

    AST_PC_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(redirect_i)) |-> (pc_o == $past(pc_o) + 32'd4)); // R2
    AST_PC_TAKES_TARGET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(redirect_i)) |-> (pc_o == $past(target_i))); // R5
    AST_PC_RESET_VAL: assert property (@(posedge clk)
        $past(rst) |-> (pc_o == RESET_PC)); // R1
endmodule

// File: rtl/fe_kill_mux.sv
module fe_kill_mux
    import fe_pkg::*;
(
    input  logic  kill_i,
    input  word_t word_i,
    output word_t word_o
);
    always_comb begin
        word_o = kill_i ? NOP_WORD : word_i;
    end
endmodule

// File: rtl/fe_stage_reg.sv
module fe_stage_reg
    import fe_pkg::*;
#(
    parameter word_t RESET_PC = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     kill_i,
    input  word_t    raw_word_i,
    input  ex_slot_t slot_i,
    output ex_slot_t slot_o
);
    ex_slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q.instr <= NOP_WORD;
            slot_q.pc    <= RESET_PC;
        end else begin
            slot_q <= slot_i;
        end
    end

    assign slot_o = slot_q;

    AST_SQUASH_NOP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kill_i)) |-> (slot_o.instr == 32'h0000_0013)); // R6
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(kill_i)) |-> (slot_o.instr == $past(raw_word_i))); // R3
    AST_RESET_NOP: assert property (@(posedge clk)
        $past(rst) |-> (slot_o.instr == 32'h0000_0013)); // R1
endmodule

// File: rtl/fe_front_end.sv
module fe_front_end
    import fe_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_word_i,
    input  logic        redirect_i,
    input  logic [31:0] redirect_pc_i,
    output logic [29:0] fetch_waddr_o,
    output logic [31:0] ex_instr_o,
    output logic [31:0] ex_pc_o
);
    word_t    pc;
    waddr_t   waddr;
    word_t    gated_word;
    ex_slot_t next_slot;
    ex_slot_t cur_slot;

    fe_pc_gen #(.RESET_PC(RESET_PC)) u_pc_gen (
        .clk        (clk),
        .rst        (rst),
        .redirect_i (redirect_i),
        .target_i   (redirect_pc_i),
        .pc_o       (pc),
        .waddr_o    (waddr)
    );

    fe_kill_mux u_kill_mux (
        .kill_i (redirect_i),
        .word_i (fetch_word_i),
        .word_o (gated_word)
    );

    always_comb begin
        next_slot.instr = gated_word;
        next_slot.pc    = pc;
    end

    fe_stage_reg #(.RESET_PC(RESET_PC)) u_stage_reg (
        .clk        (clk),
        .rst        (rst),
        .kill_i     (redirect_i),
        .raw_word_i (fetch_word_i),
        .slot_i     (next_slot),
        .slot_o     (cur_slot)
    );

    assign fetch_waddr_o = waddr;
    assign ex_instr_o    = cur_slot.instr;
    assign ex_pc_o       = cur_slot.pc;

    AST_EX_PC_TRACK: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ex_pc_o == {$past(fetch_waddr_o), 2'b00} + ($past(pc) & 32'd3))); // R4
endmodule

// File: tb/fe_front_end_bench.sv
module fe_front_end_bench;
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_word;
    logic        redirect = 1'b0;
    logic [31:0] redirect_pc = '0;
    logic [29:0] fetch_waddr;
    logic [31:0] ex_instr;
    logic [31:0] ex_pc;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [31:0] ref_pc;
    logic [31:0] ref_instr;
    logic [31:0] ref_expc;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    fe_front_end u_fe_front_end (
        .clk           (clk),
        .rst           (rst),
        .fetch_word_i  (fetch_word),
        .redirect_i    (redirect),
        .redirect_pc_i (redirect_pc),
        .fetch_waddr_o (fetch_waddr),
        .ex_instr_o    (ex_instr),
        .ex_pc_o       (ex_pc)
    );

    function automatic logic [31:0] imem(input logic [29:0] w);
        return {w[15:0], ~w[15:0]} ^ 32'h3C5A_0000;
    endfunction

    always_comb fetch_word = imem(fetch_waddr);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, "fetch_waddr", {2'b00, fetch_waddr}, {2'b00, ref_pc[31:2]});
        check(req, "ex_instr", ex_instr, ref_instr);
        check(req, "ex_pc", ex_pc, ref_expc);
    endtask

    // called at a negedge: drive, step model, wait one cycle, compare
    task automatic step(input logic rd, input logic [31:0] tgt, input string req);
        redirect    = rd;
        redirect_pc = tgt;
        ref_instr   = rd ? NOP : imem(ref_pc[31:2]);
        ref_expc    = ref_pc;
        ref_pc      = rd ? tgt : ref_pc + 32'd4;
        @(posedge clk);
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic do_reset(input string req);
        rst = 1'b1;
        redirect = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        ref_pc = 32'h0; ref_instr = NOP; ref_expc = 32'h0;
        compare_all(req);
        rst = 1'b0;
        compare_all(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset("R1");
        // sequential fetch, R2 R3 R4
        for (int i = 0; i < 20; i++) step(1'b0, 32'h0, "R2_R3_R4");
        // single redirect, R5 R6
        step(1'b1, 32'h0000_0100, "R5_R6");
        for (int i = 0; i < 4; i++) step(1'b0, 32'h0, "R5");
        // back-to-back redirects, R7
        step(1'b1, 32'h0000_0400, "R7");
        step(1'b1, 32'h0000_0040, "R7");
        step(1'b1, 32'h0000_1000, "R7");
        step(1'b0, 32'h0, "R7");
        // unaligned target keeps low bits in PC, R5
        step(1'b1, 32'h0000_0203, "R5");
        step(1'b0, 32'h0, "R5");
        step(1'b0, 32'h0, "R5");
        // target toggling while flag low, R8
        for (int i = 0; i < 8; i++) step(1'b0, 32'hDEAD_0000 ^ (i * 32'h1111), "R8");
        // mid-run reset, R1
        do_reset("R1");
        step(1'b0, 32'hFFFF_FFFC, "R1_R8");
        // pseudo-random mix, R2 R6 R7
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[1:0] == 2'b00, {lfsr, lfsr[7:0], 6'b0, lfsr[3:2]}, "R2_R6_R7");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule